// File: doc/BRIEF.md
# Keyed Decimal Entry Adder

This block takes six decimal digits, typed one at a time on a keyboard, and adds them as two three-digit numbers. Each digit arrives as a keyboard make code together with a one-cycle receive strobe from an upstream serial receiver. A four-phase sequencer accepts the strobe, decodes the code to a BCD nibble, and writes the nibble into the next free slot of a six-slot store. After the sixth digit it stops taking input. The first three digits form operand A and the last three form operand B. Each operand is turned into binary by a weighted sum of its digits, and the two values are added.

The 11-bit sum and a 12-bit zero-padded copy for a three-digit hex display stay valid until the user presses the enter key. Enter starts a new entry. Reset is synchronous and active-high. It returns the sequencer to its idle phase and clears the store, the slot pointer and the result.

Top module: `keyed_bcd_adder`

## Requirements
- R1: In phase WAIT (`phase`=0), a `scan_done` strobe with a code other than 0x5A moves the block to phase DECODE (`phase`=1) on the next edge. Strobes in any other phase have no effect on phase, store or result.
- R2: Phase DECODE lasts exactly one cycle. In that cycle the latched code is decoded, and the next phase is always STORE (`phase`=2).
- R3: In phase STORE the decoded digit is written to the slot chosen by the slot pointer. The block then goes back to WAIT, or to HOLD (`phase`=3) when the written slot was the sixth.
- R4: The slot pointer moves through 0 to 5, advancing by one on each store and returning to 0 after slot 5. After five digits no result is valid. After the sixth, a result is valid.
- R5: The six 4-bit slots change only in STORE cycles, and only one slot per store.
- R6: Make codes decode as 0x45→0, 0x16→1, 0x1E→2, 0x26→3, 0x25→4, 0x2E→5, 0x36→6, 0x3D→7, 0x3E→8, 0x46→9. Every other code stores 0.
- R7: Digits 1 to 3 form operand A and digits 4 to 6 form operand B. Within each operand, the earlier digit is more significant.
- R8: Each operand's binary value is hundreds×100 + tens×10 + ones, held in 10 bits, so its maximum is 999.
- R9: `sum` is the 11-bit sum A+B with no carry-in. `sum_hex` is `sum` with one zero bit above it, 12 bits wide.
- R10: `result_valid` rises one cycle after HOLD is entered. While valid, `sum` is held. A high `enter_key` in HOLD returns to WAIT and clears `result_valid` on the same edge.
- R11: A strobe carrying the enter code 0x5A in WAIT is ignored. It neither advances the phase nor takes a slot.
- R12: While `rst` is high at an edge, the block goes to WAIT and the slots, pointer, `sum` and `result_valid` clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_code | input | 8 | Keyboard make code, valid with `scan_done` |
| scan_done | input | 1 | One-cycle strobe: a key code is present |
| enter_key | input | 1 | Enter pressed; releases the held result |
| sum | output | 11 | Binary sum of the two operands |
| sum_hex | output | 12 | Zero-padded sum for three hex digits |
| phase | output | 2 | Sequencer phase: 0 WAIT, 1 DECODE, 2 STORE, 3 HOLD |
| result_valid | output | 1 | Sum is complete and held |

## Verification
A sweep sets every digit value in every slot position, and a pair is chosen so the digits sum to 999 in each position. This finds wrong decode entries and wrong weights. About a hundred arithmetic pairs, including 0+0 and 999+999, test the weighted conversion and the full 11-bit carry. Asymmetric entries such as 527+304 catch swapped operands or reversed digit order that symmetric values would hide. Extra strobes during DECODE, STORE and HOLD, an enter code in WAIT, and a reset part-way through an entry show whether stray input, a pointer that does not wrap, or data left in the store can change the next result.

// File: rtl/kbadd_pkg.sv
package kbadd_pkg;

    typedef enum logic [1:0] {
        PH_WAIT   = 2'd0,
        PH_DECODE = 2'd1,
        PH_STORE  = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    typedef struct packed {
        logic latch_code;
        logic decode_en;
        logic store_en;
        logic hold;
    } ctl_t;

    localparam logic [7:0] KEY_ENTER = 8'h5A;

    function automatic int unsigned pow10(input int unsigned n);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    // Set-2 make codes of the digit keys; anything else reads as zero.
    function automatic logic [3:0] scan_to_digit(input logic [7:0] code);
        logic [3:0] d;
        case (code)
            8'h16:   d = 4'd1;
            8'h1E:   d = 4'd2;
            8'h26:   d = 4'd3;
            8'h25:   d = 4'd4;
            8'h2E:   d = 4'd5;
            8'h36:   d = 4'd6;
            8'h3D:   d = 4'd7;
            8'h3E:   d = 4'd8;
            8'h46:   d = 4'd9;
            default: d = 4'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/kbadd_ctrl.sv
module kbadd_ctrl
    import kbadd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] scan_code,
    input  logic       scan_done,
    input  logic       enter_key,
    input  logic       last_slot,
    output phase_t     phase,
    output ctl_t       ctl
);

    phase_t phase_q, phase_d;

    always_comb begin
        ctl.latch_code = (phase_q == PH_WAIT) && scan_done && (scan_code != KEY_ENTER);
        ctl.decode_en  = (phase_q == PH_DECODE);
        ctl.store_en   = (phase_q == PH_STORE);
        ctl.hold       = (phase_q == PH_HOLD);
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_WAIT:   if (ctl.latch_code) phase_d = PH_DECODE;
            PH_DECODE: phase_d = PH_STORE;
            PH_STORE:  phase_d = last_slot ? PH_HOLD : PH_WAIT;
            PH_HOLD:   if (enter_key) phase_d = PH_WAIT;
            default:   phase_d = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_WAIT;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

    p_wait_advance_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && scan_done && scan_code != KEY_ENTER) |=> phase == PH_DECODE);

    p_decode_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_DECODE |=> phase == PH_STORE);

    p_store_exit_r3: assert property (@(posedge clk) disable iff (rst)
        phase == PH_STORE |=> (phase == PH_WAIT || phase == PH_HOLD));

    p_enter_code_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && scan_done && scan_code == KEY_ENTER) |=> phase == PH_WAIT);

    p_hold_release_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && enter_key) |=> phase == PH_WAIT);

endmodule

// File: rtl/kbadd_keystage.sv
module kbadd_keystage
    import kbadd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       latch_code,
    input  logic       decode_en,
    input  logic [7:0] scan_code,
    output logic [3:0] digit
);

    logic [7:0] code_q;
    logic [3:0] digit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            digit_q <= '0;
        end else begin
            if (latch_code) code_q  <= scan_code;
            if (decode_en)  digit_q <= scan_to_digit(code_q);
        end
    end

    assign digit = digit_q;

    p_digit_is_bcd_r6: assert property (@(posedge clk) disable iff (rst)
        digit_q <= 4'd9);

endmodule

// File: rtl/kbadd_store.sv
module kbadd_store #(
    parameter int SLOTS = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [3:0]         din,
    output logic [SLOTS*4-1:0] slots,
    output logic               last_slot
);

    localparam int ADDR_W = $clog2(SLOTS);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SLOTS - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [SLOTS-1:0]  wr_sel;
    logic [SLOTS*4-1:0] slots_q;

    assign last_slot = (addr_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)     addr_q <= '0;
        else if (we) addr_q <= last_slot ? '0 : addr_q + 1'b1;
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign wr_sel[k] = we && (addr_q == ADDR_W'(k));
        always_ff @(posedge clk) begin
            if (rst)            slots_q[k*4 +: 4] <= '0;
            else if (wr_sel[k]) slots_q[k*4 +: 4] <= din;
        end
    end

    assign slots = slots_q;

    p_addr_range_r4: assert property (@(posedge clk) disable iff (rst)
        addr_q <= LAST);

    p_addr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (we && addr_q == LAST) |=> addr_q == '0);

    p_store_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(slots_q));

    p_single_slot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

endmodule

// File: rtl/kbadd_bcd2bin.sv
module kbadd_bcd2bin
    import kbadd_pkg::*;
#(
    parameter int DIGITS = 3,
    parameter int BIN_W  = 10
) (
    input  logic [DIGITS*4-1:0] bcd,
    output logic [BIN_W-1:0]    bin
);

    // Weighted multiply-add; the top nibble carries the highest power of ten.
    always_comb begin
        bin = '0;
        for (int j = 0; j < DIGITS; j++) begin
            bin = bin + BIN_W'(bcd[j*4 +: 4]) * BIN_W'(pow10(j));
        end
    end

endmodule

// File: rtl/keyed_bcd_adder.sv
module keyed_bcd_adder
    import kbadd_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  scan_code,
    input  logic        scan_done,
    input  logic        enter_key,
    output logic [10:0] sum,
    output logic [11:0] sum_hex,
    output logic [1:0]  phase,
    output logic        result_valid
);

    localparam int OPERANDS = 2;
    localparam int SLOTS    = OPERANDS * DIGITS;
    localparam int BIN_W    = $clog2(pow10(DIGITS));
    localparam int SUM_W    = BIN_W + 1;
    localparam int HEX_W    = ((SUM_W + 3) / 4) * 4;

    phase_t             phase_w;
    ctl_t               ctl;
    logic               last_slot;
    logic [3:0]         digit;
    logic [SLOTS*4-1:0] slots;
    logic [DIGITS*4-1:0] opnd_bcd [OPERANDS];
    logic [BIN_W-1:0]   opnd_bin [OPERANDS];
    logic [SUM_W-1:0]   sum_raw, sum_q;
    logic               valid_q;

    kbadd_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .scan_code (scan_code),
        .scan_done (scan_done),
        .enter_key (enter_key),
        .last_slot (last_slot),
        .phase     (phase_w),
        .ctl       (ctl)
    );

    kbadd_keystage u_keystage (
        .clk        (clk),
        .rst        (rst),
        .latch_code (ctl.latch_code),
        .decode_en  (ctl.decode_en),
        .scan_code  (scan_code),
        .digit      (digit)
    );

    kbadd_store #(.SLOTS(SLOTS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (ctl.store_en),
        .din       (digit),
        .slots     (slots),
        .last_slot (last_slot)
    );

    // Slot order is entry order; first digit of each operand is its top nibble.
    for (genvar g = 0; g < OPERANDS; g++) begin : g_opnd
        for (genvar j = 0; j < DIGITS; j++) begin : g_dig
            assign opnd_bcd[g][(DIGITS-1-j)*4 +: 4] = slots[(g*DIGITS + j)*4 +: 4];
        end
        kbadd_bcd2bin #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_conv (
            .bcd (opnd_bcd[g]),
            .bin (opnd_bin[g])
        );
    end

    assign sum_raw = SUM_W'(opnd_bin[0]) + SUM_W'(opnd_bin[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (ctl.hold) sum_q <= sum_raw;
            valid_q <= ctl.hold && !enter_key;
        end
    end

    assign sum          = sum_q;
    assign sum_hex      = {{(HEX_W-SUM_W){1'b0}}, sum_q};
    assign phase        = phase_w;
    assign result_valid = valid_q;

    p_operand_max_r8: assert property (@(posedge clk) disable iff (rst)
        (opnd_bin[0] <= BIN_W'(pow10(DIGITS) - 1)) && (opnd_bin[1] <= BIN_W'(pow10(DIGITS) - 1)));

    p_valid_in_hold_r10: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> phase_w == PH_HOLD);

    p_sum_held_r10: assert property (@(posedge clk) disable iff (rst)
        (result_valid && $past(result_valid)) |-> $stable(sum));

    p_valid_follows_hold_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(result_valid) |-> $past(phase_w == PH_HOLD));

    p_reset_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_w == PH_WAIT && !result_valid && sum == '0));

endmodule

// File: tb/keyed_bcd_adder_bench.sv
module keyed_bcd_adder_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  scan_code;
    logic        scan_done;
    logic        enter_key;
    logic [10:0] sum;
    logic [11:0] sum_hex;
    logic [1:0]  phase;
    logic        result_valid;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_bcd_adder u_keyed_bcd_adder (
        .clk          (clk),
        .rst          (rst),
        .scan_code    (scan_code),
        .scan_done    (scan_done),
        .enter_key    (enter_key),
        .sum          (sum),
        .sum_hex      (sum_hex),
        .phase        (phase),
        .result_valid (result_valid)
    );

    function automatic logic [7:0] code_of(input int d);
        case (d)
            0: return 8'h45;  1: return 8'h16;  2: return 8'h1E;
            3: return 8'h26;  4: return 8'h25;  5: return 8'h2E;
            6: return 8'h36;  7: return 8'h3D;  8: return 8'h3E;
            default: return 8'h46;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic press(input logic [7:0] code);
        @(negedge clk);
        scan_code = code;
        scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic release_result();
        @(negedge clk);
        enter_key = 1'b1;
        @(negedge clk);
        enter_key = 1'b0;
    endtask

    task automatic run_pair(input int a, input int b, input string req);
        press(code_of(a / 100));
        press(code_of((a / 10) % 10));
        press(code_of(a % 10));
        press(code_of(b / 100));
        press(code_of((b / 10) % 10));
        press(code_of(b % 10));
        chk({req, " valid"}, int'(result_valid), 1);
        chk({req, " sum"}, int'(sum), a + b);
        chk("R9 hex", int'(sum_hex), a + b);
        release_result();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; scan_code = '0; scan_done = 1'b0; enter_key = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 reset phase", int'(phase), 0);
        chk("R12 reset valid", int'(result_valid), 0);
        chk("R12 reset sum", int'(sum), 0);
        rst = 1'b0;

        // Phase trace with stray strobes in DECODE and STORE (R1, R2, R3)
        @(negedge clk);
        scan_code = code_of(5); scan_done = 1'b1;
        @(negedge clk);
        chk("R1 strobe to DECODE", int'(phase), 1);
        scan_code = code_of(9);
        @(negedge clk);
        chk("R2 DECODE to STORE", int'(phase), 2);
        scan_code = code_of(8);
        @(negedge clk);
        scan_done = 1'b0;
        chk("R3 STORE to WAIT", int'(phase), 0);
        repeat (2) @(negedge clk);
        chk("R1 stays WAIT", int'(phase), 0);

        // Enter code in WAIT must be ignored (R11)
        @(negedge clk);
        scan_code = 8'h5A; scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
        chk("R11 enter code ignored", int'(phase), 0);
        repeat (2) @(negedge clk);

        // 527 + 304 with a non-digit code as the middle digit of B (R6, R7)
        press(code_of(2));
        press(code_of(7));
        press(code_of(3));
        press(8'h1C);
        chk("R4 no result after five", int'(result_valid), 0);
        press(code_of(4));
        chk("R4 valid after six", int'(result_valid), 1);
        chk("R7 operand order", int'(sum), 831);
        chk("R9 hex", int'(sum_hex), 831);

        // Held result with stray strobes in HOLD (R10, R1)
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            scan_code = code_of(k + 1); scan_done = 1'b1;
        end
        @(negedge clk);
        scan_done = 1'b0;
        chk("R10 held phase", int'(phase), 3);
        chk("R10 held valid", int'(result_valid), 1);
        chk("R10 held sum", int'(sum), 831);
        release_result();
        chk("R10 enter to WAIT", int'(phase), 0);
        chk("R10 valid cleared", int'(result_valid), 0);

        // Order sensitivity (R7)
        run_pair(123, 456, "R7");
        run_pair(321, 654, "R7");

        // Every digit in every position (R6, R8)
        for (int d = 0; d < 10; d++) begin
            run_pair(d * 111, (9 - d) * 111, "R6");
        end

        // Extremes and arithmetic sweep (R8, R9, R4 wrap across entries)
        run_pair(0, 0, "R8");
        run_pair(999, 999, "R9");
        run_pair(100, 1, "R8");
        run_pair(9, 90, "R8");
        for (int i = 0; i < 100; i++) begin
            run_pair((i * 7919 + 3) % 1000, (i * 104729 + 500) % 1000, "R8");
        end

        // Reset part-way through an entry (R12)
        press(code_of(9));
        press(code_of(9));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R12 mid-entry phase", int'(phase), 0);
        chk("R12 mid-entry valid", int'(result_valid), 0);
        run_pair(1, 2, "R12");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule